// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Front End

This block is the bus-facing part of a small byte-addressed nonvolatile store. The array is modelled as a register file of 2^ADDR_W bytes (512 by default). A two-wire master talks to it over SCL and an open-drain SDA. The SDA line is shown as a pull-down enable (`sda_oe`) plus the sampled line level (`sda_in`). Both bus inputs are brought into the system clock domain through a synchroniser. START and STOP are then recognised from the synchronised levels.

A write transfer has three parts: the device address byte with R/W = 0, two word-address bytes (high byte first), and one or more data bytes. The data bytes are held in a small load buffer. A valid STOP then starts a timed internal write cycle, which copies the buffer into the array at consecutive, wrapping addresses. While that cycle runs the bus is ignored, so a master can poll with address bytes until one is acknowledged. Reads come from an internal address counter and take three forms: current-address reads, random reads (a dummy write, then a repeated START with R/W = 1) and sequential reads.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: SCL and SDA are sampled through a synchroniser of at least two flip-flops. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A new START always restarts address decoding, even after an address that did not match.
- R2: After a START, the first byte is the device address: bits 7..1 are compared with DEV_ADDR (default 7'h50) and bit 0 is R/W, where 1 means read. On a match the slave pulls SDA low during the ninth clock. On a mismatch SDA stays released for the rest of the transfer. SDA is released after reset.
- R3: After a write address, the next two bytes are the word address, high byte first. The array address is the low ADDR_W bits of that 16-bit value. Each of these bytes is acknowledged, and the last one loads the address counter.
- R4: Data bytes that follow the word address are acknowledged and buffered. They are written to the array only when a STOP arrives after at least one complete data byte and its acknowledge clock. Data byte k goes to word address + k.
- R5: A STOP in the middle of a data byte, or before the first data byte has been acknowledged, leaves the array unchanged and starts no write cycle. The next address byte is therefore acknowledged at once.
- R6: A committing STOP starts an internal write cycle of WRITE_CYCLES system clocks. During that cycle no address byte is acknowledged, whether it is a read or a write. The first address byte sent after the cycle ends is acknowledged.
- R7: A read address byte is acknowledged. The slave then drives eight data bits, MSB first, from the address counter location and advances the counter by one. SDA changes only while SCL is low.
- R8: A current-address read returns the byte after the last one accessed. After a committed write, that is the byte after the last one written.
- R9: A random read, made of a dummy write that ends with the word address and then a repeated START with R/W = 1, returns data from the newly loaded address and commits nothing.
- R10: During a read, a master ACK (SDA low on the ninth clock) makes the slave send the byte at the next address. A master NACK followed by STOP ends the read, and SDA stays released.
- R11: The address counter wraps from the last array location to 0, both for multi-byte writes and for sequential reads.
- R12: The load buffer holds BUF_DEPTH bytes (default 16). Data bytes beyond that are acknowledged but discarded. After the commit, the counter points to word address + BUF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
Every slave response is due a fixed number of cycles after an SCL edge, and the bench samples each one well after it is due:
- **Acknowledge and read data bits:** the synchroniser and the edge register add three system clocks after the SCL falling edge that selects the value. The bench samples the line a quarter SCL period after the next rising edge, at least ten system clocks after that falling edge.
- **Write cycle:** the busy window opens two clocks after the STOP is detected and lasts WRITE_CYCLES clocks. The bench polls with address bytes straight after each committing STOP. It requires the first poll to be refused, and it requires the acknowledged poll to come at least WRITE_CYCLES clocks after the STOP.
- **Array contents:** the bench checks them by reading back through the bus against a model that only records bytes whose write was committed.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_RDATA,
      ST_WAIT
   } slv_state_e;

   localparam int unsigned WORD_ADDR_BYTES = 2;

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   initial begin : elab_chk
      assert (STAGES >= 2) else $error("synchroniser needs at least two stages");
   end

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_in};
         sda_q <= {sda_q[STAGES-2:0], sda_in};
         scl_d <= scl_q[STAGES-1];
         sda_d <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store #(
   parameter int unsigned ADDR_W       = 9,
   parameter int unsigned BUF_DEPTH    = 16,
   parameter int unsigned WRITE_CYCLES = 500000,
   localparam int unsigned DEPTH = 1 << ADDR_W,
   localparam int unsigned BI_W  = $clog2(BUF_DEPTH),
   localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1),
   localparam int unsigned TMR_W = $clog2(WRITE_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_we,
   input  logic [BI_W-1:0]   buf_idx,
   input  logic [7:0]        buf_data,
   input  logic              commit,
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  count,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);

   initial begin : elab_chk
      assert (WRITE_CYCLES >= BUF_DEPTH) else $error("write cycle shorter than buffer drain");
      assert (TMR_W >= CNT_W) else $error("timer narrower than byte count");
   end

   logic [7:0]        mem  [DEPTH];
   logic [7:0]        wbuf [BUF_DEPTH];
   logic [TMR_W-1:0]  tmr;
   logic [ADDR_W-1:0] wbase;
   logic [CNT_W-1:0]  wcnt;
   logic              drain;

   always_ff @(posedge clk) begin
      if (buf_we) wbuf[buf_idx] <= buf_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         tmr   <= '0;
         wbase <= '0;
         wcnt  <= '0;
      end else if (commit) begin
         busy  <= 1'b1;
         tmr   <= '0;
         wbase <= base;
         wcnt  <= count;
      end else if (busy) begin
         if (tmr == TMR_W'(WRITE_CYCLES - 1)) busy <= 1'b0;
         tmr <= tmr + TMR_W'(1);
      end
   end

   assign drain = busy && (tmr < TMR_W'(wcnt));

   always_ff @(posedge clk) begin
      if (drain) mem[wbase + ADDR_W'(tmr)] <= wbuf[tmr[BI_W-1:0]];
   end

   assign rd_data = mem[rd_addr];

   AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !busy); // R4

   AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tmr) == TMR_W'(WRITE_CYCLES - 1)); // R6

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
   import eeprom_i2c_pkg::*;
#(
   parameter int unsigned ADDR_W       = 9,
   parameter logic [6:0]  DEV_ADDR     = 7'h50,
   parameter int unsigned BUF_DEPTH    = 16,
   parameter int unsigned WRITE_CYCLES = 500000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_oe
);

   localparam int unsigned BI_W  = $clog2(BUF_DEPTH);
   localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);

   initial begin : elab_chk
      assert (ADDR_W >= 1 && ADDR_W <= 8 * WORD_ADDR_BYTES) else $error("ADDR_W out of range");
      assert (BUF_DEPTH >= 2 && (BUF_DEPTH & (BUF_DEPTH - 1)) == 0) else $error("BUF_DEPTH must be a power of two");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   eeprom_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   slv_state_e        state;
   logic [3:0]        bitc;
   logic [7:0]        shreg, tx;
   logic              rd_mode, mack, oe_q;
   logic [1:0]        wa_idx;
   logic [ADDR_W-1:0] wa_acc, addr_ctr, wr_base;
   logic [CNT_W-1:0]  wr_cnt;
   logic              buf_we, commit, busy;
   logic [BI_W-1:0]   buf_idx;
   logic [7:0]        buf_data, rd_data;

   eeprom_byte_store #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
      .commit(commit), .base(wr_base), .count(wr_cnt), .rd_addr(addr_ctr),
      .rd_data(rd_data), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitc     <= '0;
         shreg    <= '0;
         tx       <= '0;
         rd_mode  <= 1'b0;
         mack     <= 1'b0;
         oe_q     <= 1'b0;
         wa_idx   <= '0;
         wa_acc   <= '0;
         addr_ctr <= '0;
         wr_base  <= '0;
         wr_cnt   <= '0;
         buf_we   <= 1'b0;
         buf_idx  <= '0;
         buf_data <= '0;
         commit   <= 1'b0;
      end else begin
         buf_we <= 1'b0;
         commit <= 1'b0;
         if (busy) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
         end else if (start_det) begin
            state  <= ST_DEV;
            bitc   <= '0;
            oe_q   <= 1'b0;
            wa_idx <= '0;
            wr_cnt <= '0;
         end else if (stop_det) begin
            if (state == ST_WDATA && wr_cnt != '0 && bitc <= 4'd1) begin
               commit   <= 1'b1;
               addr_ctr <= wr_base + ADDR_W'(wr_cnt);
            end
            state <= ST_IDLE;
            oe_q  <= 1'b0;
         end else if (state != ST_IDLE && state != ST_WAIT) begin
            if (scl_rise) begin
               if (bitc < 4'd8) shreg <= {shreg[6:0], sda_s};
               else if (state == ST_RDATA) mack <= ~sda_s;
               bitc <= bitc + 4'd1;
            end else if (scl_fall) begin
               if (bitc == 4'd8) begin
                  case (state)
                     ST_DEV: begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           oe_q    <= 1'b1;
                           rd_mode <= shreg[0];
                        end else begin
                           state <= ST_WAIT;
                        end
                     end
                     ST_WADDR: begin
                        oe_q   <= 1'b1;
                        wa_acc <= ADDR_W'({wa_acc, shreg});
                     end
                     ST_WDATA: begin
                        oe_q <= 1'b1;
                        if (wr_cnt < CNT_W'(BUF_DEPTH)) begin
                           buf_we   <= 1'b1;
                           buf_idx  <= wr_cnt[BI_W-1:0];
                           buf_data <= shreg;
                        end
                     end
                     default: oe_q <= 1'b0;
                  endcase
               end else if (bitc == 4'd9) begin
                  bitc <= '0;
                  oe_q <= 1'b0;
                  case (state)
                     ST_DEV: begin
                        if (rd_mode) begin
                           state    <= ST_RDATA;
                           tx       <= rd_data;
                           addr_ctr <= addr_ctr + ADDR_W'(1);
                           oe_q     <= ~rd_data[7];
                        end else begin
                           state <= ST_WADDR;
                        end
                     end
                     ST_WADDR: begin
                        if (wa_idx == 2'(WORD_ADDR_BYTES - 1)) begin
                           addr_ctr <= wa_acc;
                           wr_base  <= wa_acc;
                           wr_cnt   <= '0;
                           state    <= ST_WDATA;
                        end else begin
                           wa_idx <= wa_idx + 2'd1;
                        end
                     end
                     ST_WDATA: begin
                        if (wr_cnt < CNT_W'(BUF_DEPTH)) wr_cnt <= wr_cnt + CNT_W'(1);
                     end
                     ST_RDATA: begin
                        if (mack) begin
                           tx       <= rd_data;
                           addr_ctr <= addr_ctr + ADDR_W'(1);
                           oe_q     <= ~rd_data[7];
                        end else begin
                           state <= ST_WAIT;
                        end
                     end
                     default: ;
                  endcase
               end else if (state == ST_RDATA) begin
                  oe_q <= ~tx[3'd7 - bitc[2:0]];
               end
            end
         end
      end
   end

   assign sda_oe = oe_q;

   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe); // R6

   AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe)); // R7

   AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE)); // R1

   AST_NO_COMMIT_OUTSIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(state) == ST_WDATA); // R5

endmodule

// File: tb/tb_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module tb_eeprom_i2c_slave;

   localparam int WC = 300;
   localparam int BUFD = 16;
   localparam int Q = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   always #5 clk = ~clk;

   eeprom_i2c_slave #(.WRITE_CYCLES(WC)) dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
   );

   logic [7:0] ref_mem [512];
   bit         known   [512];
   logic [7:0] wbuf    [32];
   logic [7:0] rbuf    [32];
   int         exp_ctr;
   bit         ctr_ok;
   int         n_chk, n_err;
   time        t_stop;

   function automatic logic [7:0] dev_byte(input bit rd);
      return {7'h50, rd};
   endfunction

   function automatic int wrapa(input int a);
      return a & 511;
   endfunction

   function automatic int kept(input int n);
      return (n > BUFD) ? BUFD : n;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
   endtask

   task automatic bit_out(input bit b);
      sda_m = b; #Q; scl = 1'b1; #Q; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bit_in(output bit b);
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; b = sda_line; #Q; scl = 1'b0; #Q;
   endtask

   task automatic send_byte(input logic [7:0] d, output bit ack);
      bit a;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(a);
      ack = ~a;
   endtask

   task automatic recv_byte(output logic [7:0] d, input bit mack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
      bit_out(~mack);
   endtask

   task automatic wait_ready();
      bit ak;
      bit first = 1'b1;
      int cyc;
      ak = 1'b0;
      for (int p = 0; p < 40; p++) begin
         bus_start();
         send_byte(dev_byte(1'b0), ak);
         bus_stop();
         if (first) chk(!ak, "R6 address refused during write cycle", ak, 0);
         first = 1'b0;
         if (ak) break;
      end
      cyc = int'(($time - t_stop) / 10);
      chk(ak && cyc >= WC, "R6 address acked only after write cycle", cyc, WC);
   endtask

   task automatic wr_txn(input int a, input int n);
      bit ak;
      bus_start();
      send_byte(dev_byte(1'b0), ak);
      chk(ak, "R1 R2 write address ack", ak, 1);
      send_byte(8'((a >> 8) & 255), ak);
      chk(ak, "R3 word address high ack", ak, 1);
      send_byte(8'(a & 255), ak);
      chk(ak, "R3 word address low ack", ak, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], ak);
         chk(ak, (i >= BUFD) ? "R12 overflow byte ack" : "R4 data ack", ak, 1);
      end
      bus_stop();
      t_stop = $time;
      for (int i = 0; i < kept(n); i++) begin
         ref_mem[wrapa(a + i)] = wbuf[i];
         known[wrapa(a + i)] = 1'b1;
      end
      exp_ctr = wrapa(a + kept(n));
      ctr_ok = 1'b1;
      wait_ready();
   endtask

   task automatic rd_txn(input int a, input int n);
      bit ak;
      bus_start();
      send_byte(dev_byte(1'b0), ak);
      chk(ak, "R9 dummy write ack", ak, 1);
      send_byte(8'((a >> 8) & 255), ak);
      chk(ak, "R3 word address high ack", ak, 1);
      send_byte(8'(a & 255), ak);
      chk(ak, "R3 word address low ack", ak, 1);
      bus_start();
      send_byte(dev_byte(1'b1), ak);
      chk(ak, "R7 read address ack", ak, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(rbuf[i], i != n - 1);
         if (known[wrapa(a + i)])
            chk(rbuf[i] == ref_mem[wrapa(a + i)],
                (a + i >= 512) ? "R11 wrapped read" : ((i > 0) ? "R10 sequential read" : "R7 R9 random read"),
                rbuf[i], ref_mem[wrapa(a + i)]);
      end
      bus_stop();
      #Q;
      chk(sda_oe == 1'b0, "R10 SDA released after NACK and STOP", sda_oe, 0);
      exp_ctr = wrapa(a + n);
      ctr_ok = 1'b1;
   endtask

   task automatic cur_rd(input int n);
      bit ak;
      bus_start();
      send_byte(dev_byte(1'b1), ak);
      chk(ak, "R7 current read address ack", ak, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(rbuf[i], i != n - 1);
         if (known[wrapa(exp_ctr + i)])
            chk(rbuf[i] == ref_mem[wrapa(exp_ctr + i)], "R8 current address read",
                rbuf[i], ref_mem[wrapa(exp_ctr + i)]);
      end
      bus_stop();
      exp_ctr = wrapa(exp_ctr + n);
   endtask

   initial begin : watchdog
      #(190000 * 10);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

   initial begin : main
      bit ak;
      logic [7:0] keep_a, keep_b;
      void'($urandom(32'd4242));
      n_chk = 0;
      n_err = 0;
      ctr_ok = 1'b0;
      exp_ctr = 0;
      for (int i = 0; i < 512; i++) known[i] = 1'b0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      chk(sda_oe == 1'b0, "R2 SDA released after reset", sda_oe, 0);

      // R2: mismatching address is not acknowledged, R1: next START recovers
      bus_start();
      send_byte({7'h52, 1'b0}, ak);
      chk(!ak, "R2 foreign address not acked", ak, 0);
      send_byte(8'h00, ak);
      chk(!ak, "R2 SDA stays released after mismatch", ak, 0);
      bus_start();
      send_byte(dev_byte(1'b0), ak);
      chk(ak, "R1 new START restarts decode", ak, 1);
      bus_stop();

      // basic write, then random and sequential read
      wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h00; wbuf[3] = 8'hFF;
      wr_txn(16, 4);
      rd_txn(16, 4);

      // R8: counter after a write and after a read
      for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h60 + i);
      wr_txn(80, 4);
      wbuf[0] = 8'h9E;
      wr_txn(80, 1);
      cur_rd(2);
      rd_txn(32 + 80, 0 + 1);
      rd_txn(80, 1);
      cur_rd(3);

      // R5: STOP in the middle of a data byte
      bus_start();
      send_byte(dev_byte(1'b0), ak);
      send_byte(8'h00, ak);
      send_byte(8'd16, ak);
      for (int i = 0; i < 4; i++) bit_out(i[0]);
      bus_stop();
      bus_start();
      send_byte(dev_byte(1'b0), ak);
      chk(ak, "R5 no write cycle after mid-byte STOP", ak, 1);
      bus_stop();
      rd_txn(16, 1);
      chk(rbuf[0] == ref_mem[16], "R5 array unchanged after mid-byte STOP", rbuf[0], ref_mem[16]);

      // R5: STOP before first data byte acknowledged
      bus_start();
      send_byte(dev_byte(1'b0), ak);
      send_byte(8'h00, ak);
      send_byte(8'd17, ak);
      bus_stop();
      bus_start();
      send_byte(dev_byte(1'b0), ak);
      chk(ak, "R5 no write cycle after address-only write", ak, 1);
      bus_stop();
      rd_txn(17, 1);
      chk(rbuf[0] == ref_mem[17], "R5 array unchanged after address-only write", rbuf[0], ref_mem[17]);

      // R11: wrap on write and read
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      wr_txn(511, 3);
      rd_txn(511, 3);
      chk(rbuf[1] == 8'h22, "R11 write wrapped to address 0", rbuf[1], 8'h22);

      // R12: buffer overflow
      wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
      wr_txn(272, 2);
      keep_a = ref_mem[272];
      keep_b = ref_mem[273];
      for (int i = 0; i < 18; i++) wbuf[i] = 8'(i * 7 + 1);
      wr_txn(256, 18);
      cur_rd(2);
      chk(rbuf[0] == keep_a && rbuf[1] == keep_b, "R12 bytes past buffer discarded", rbuf[0], keep_a);

      // constrained random mix
      for (int it = 0; it < 14; it++) begin
         int op;
         int a;
         int n;
         op = int'($urandom_range(2, 0));
         a = int'($urandom_range(511, 0));
         n = int'($urandom_range(6, 1));
         if (op == 0) begin
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_txn(a, n);
         end else if (op == 1 || !ctr_ok) begin
            rd_txn(a, n);
         end else begin
            cur_rd((n > 3) ? 3 : n);
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   end

endmodule